// File: doc/BRIEF.md
# Custom Instruction Function Unit

This block is an execution unit private to one CPU core. The core hands it a command carrying a 10-bit function selector and two 32-bit operands. The unit later returns a response carrying a 32-bit result and an ok flag. Both directions use a valid/ready handshake. The unit has no system-bus port and no registers that software can see. Exactly one unit sits beside the core, so there is no routing logic.

The unit computes every operation in parallel and selects one result by the decoded function code. Supported operations are byte-order reversal of operand A, bit-order reversal of operand A, the modular sum of A and B, and A AND NOT B. Any other function code returns ok low and a zero result.

Each accepted command fills a one-entry response slot. At most one response is outstanding at a time. A new command can enter in the same cycle that the held response leaves.

Top module: `cfu_unit`

## Requirements
- R1: A synchronous active-high `rst` empties the response slot. On the first edge after `rst` is sampled high, `rsp_valid` is 0 and `rsp_result`/`rsp_ok` are 0.
- R2: `cmd_ready` is high exactly when no response is held, or when the held response is consumed in this cycle (`rsp_ready` high). While a response is held and `rsp_ready` is low, no command is accepted.
- R3: A command transfers on an edge where `cmd_valid` and `cmd_ready` are both high. Its response is presented with `rsp_valid` high from the next cycle onward.
- R4: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_result` and `rsp_ok` hold their values.
- R5: Function code 0 returns operand A with its four bytes in reverse order, and `rsp_ok` = 1.
- R6: Function code 1 returns operand A with bit i moved to bit 31-i, and `rsp_ok` = 1.
- R7: Function code 2 returns (A + B) mod 2^32, and `rsp_ok` = 1.
- R8: Function code 3 returns A & ~B, and `rsp_ok` = 1.
- R9: Any function code from 4 to 1023 returns `rsp_ok` = 0 and `rsp_result` = 0.
- R10: With `rsp_ready` held high, a command can be accepted on every cycle. A response that is consumed with no new command accepted leaves `rsp_valid` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered by the core |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_func | input | 10 | Function selector |
| cmd_op_a | input | 32 | First operand |
| cmd_op_b | input | 32 | Second operand |
| rsp_valid | output | 1 | Response is held |
| rsp_ready | input | 1 | Core takes the response this cycle |
| rsp_result | output | 32 | Operation result |
| rsp_ok | output | 1 | 1 when the function code is supported |

## Verification
The hardest situation to reach is a held response that leaves in the same edge a new command enters. This cycle drives both the drain path and the load path of the slot at once. The bench reaches it by stalling `rsp_ready` while a second command waits with `cmd_valid` high. It then releases `rsp_ready` and checks that the replacement payload appears at once, with no empty cycle. A streaming run with `rsp_ready` tied high, and a reset issued while a response is stalled, cover the other slot transitions. All 1024 function codes are swept with several operand pairs.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

   // Function selector assignments (values the core encodes).
   localparam int unsigned FN_BYTE_REV = 0;
   localparam int unsigned FN_BIT_REV  = 1;
   localparam int unsigned FN_ADD      = 2;
   localparam int unsigned FN_ANDN     = 3;

   // One-hot operation select produced by the decoder.
   typedef struct packed {
      logic byte_rev;
      logic bit_rev;
      logic add;
      logic andn;
   } op_sel_t;

endpackage

// File: rtl/cfu_op_decode.sv
module cfu_op_decode
   import cfu_pkg::*;
#(
   parameter int unsigned FUNC_W      = 10,
   parameter bit          ENABLE_ANDN = 1'b1
) (
   input  logic [FUNC_W-1:0] func,
   output op_sel_t           sel,
   output logic              known
);

   localparam logic [FUNC_W-1:0] CODE_BYTE_REV = FUNC_W'(FN_BYTE_REV);
   localparam logic [FUNC_W-1:0] CODE_BIT_REV  = FUNC_W'(FN_BIT_REV);
   localparam logic [FUNC_W-1:0] CODE_ADD      = FUNC_W'(FN_ADD);
   localparam logic [FUNC_W-1:0] CODE_ANDN     = FUNC_W'(FN_ANDN);

   generate
      if (FUNC_W < 2) begin : g_bad_width
         $error("cfu_op_decode: FUNC_W must be at least 2");
      end
   endgenerate

   logic andn_hit;

   generate
      if (ENABLE_ANDN) begin : g_andn_on
         assign andn_hit = (func == CODE_ANDN);
      end else begin : g_andn_off
         assign andn_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      sel          = '0;
      sel.byte_rev = (func == CODE_BYTE_REV);
      sel.bit_rev  = (func == CODE_BIT_REV);
      sel.add      = (func == CODE_ADD);
      sel.andn     = andn_hit;
   end

   assign known = |sel;

endmodule

// File: rtl/cfu_exec.sv
module cfu_exec
   import cfu_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  op_sel_t           sel,
   output logic [DATA_W-1:0] result
);

   localparam int unsigned N_BYTES = DATA_W / BYTE_W;

   generate
      if (BYTE_W == 0 || (DATA_W % BYTE_W) != 0) begin : g_bad_split
         $error("cfu_exec: DATA_W must be a whole multiple of BYTE_W");
      end
   endgenerate

   logic [DATA_W-1:0] byte_swapped;
   logic [DATA_W-1:0] bit_swapped;
   logic [DATA_W-1:0] summed;
   logic [DATA_W-1:0] masked;

   generate
      for (genvar gb = 0; gb < N_BYTES; gb++) begin : g_byte_lane
         assign byte_swapped[gb*BYTE_W +: BYTE_W] =
            op_a[(N_BYTES-1-gb)*BYTE_W +: BYTE_W];
      end
      for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit_lane
         assign bit_swapped[gi] = op_a[DATA_W-1-gi];
      end
   endgenerate

   assign summed = op_a + op_b;
   assign masked = op_a & ~op_b;

   // Select is one-hot or empty; an empty select yields zero.
   always_comb begin
      result = '0;
      if (sel.byte_rev) result = result | byte_swapped;
      if (sel.bit_rev)  result = result | bit_swapped;
      if (sel.add)      result = result | summed;
      if (sel.andn)     result = result | masked;
   end

endmodule

// File: rtl/cfu_rsp_slot.sv
module cfu_rsp_slot #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              drain,
   input  logic [DATA_W-1:0] in_result,
   input  logic              in_ok,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_ok
);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_ok     <= 1'b0;
      end else if (load) begin
         out_valid  <= 1'b1;
         out_result <= in_result;
         out_ok     <= in_ok;
      end else if (drain) begin
         out_valid  <= 1'b0;
      end
   end

endmodule

// File: rtl/cfu_unit.sv
module cfu_unit
   import cfu_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned FUNC_W      = 10,
   parameter int unsigned BYTE_W      = 8,
   parameter bit          ENABLE_ANDN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [FUNC_W-1:0] cmd_func,
   input  logic [DATA_W-1:0] cmd_op_a,
   input  logic [DATA_W-1:0] cmd_op_b,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_result,
   output logic              rsp_ok
);

   op_sel_t           sel;
   logic              known;
   logic [DATA_W-1:0] exec_result;
   logic              cmd_fire;
   logic              rsp_fire;

   cfu_op_decode #(
      .FUNC_W      (FUNC_W),
      .ENABLE_ANDN (ENABLE_ANDN)
   ) u_decode (
      .func  (cmd_func),
      .sel   (sel),
      .known (known)
   );

   cfu_exec #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
   ) u_exec (
      .op_a   (cmd_op_a),
      .op_b   (cmd_op_b),
      .sel    (sel),
      .result (exec_result)
   );

   assign cmd_ready = ~rsp_valid | rsp_ready;
   assign cmd_fire  = cmd_valid & cmd_ready;
   assign rsp_fire  = rsp_valid & rsp_ready;

   cfu_rsp_slot #(
      .DATA_W (DATA_W)
   ) u_slot (
      .clk        (clk),
      .rst        (rst),
      .load       (cmd_fire),
      .drain      (rsp_fire),
      .in_result  (exec_result),
      .in_ok      (known),
      .out_valid  (rsp_valid),
      .out_result (rsp_result),
      .out_ok     (rsp_ok)
   );

endmodule

// File: rtl/cfu_unit_chk.sv
module cfu_unit_chk #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned FUNC_W      = 10,
   parameter bit          ENABLE_ANDN = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [FUNC_W-1:0] cmd_func,
   input logic [DATA_W-1:0] cmd_op_a,
   input logic [DATA_W-1:0] cmd_op_b,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [DATA_W-1:0] rsp_result,
   input logic              rsp_ok
);

   logic cmd_xfer;
   logic rsp_xfer;
   assign cmd_xfer = cmd_valid & cmd_ready;
   assign rsp_xfer = rsp_valid & rsp_ready;

   assert_reset_empty_R1: assert property (@(posedge clk)
      rst |=> !rsp_valid);

   assert_no_accept_when_full_R2: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !rsp_ready) |-> !cmd_ready);

   assert_rsp_follows_cmd_R3: assert property (@(posedge clk) disable iff (rst)
      cmd_xfer |=> rsp_valid);

   assert_hold_under_stall_R4: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_result) && $stable(rsp_ok)));

   assert_andn_value_R8: assert property (@(posedge clk) disable iff (rst)
      (ENABLE_ANDN && cmd_xfer && cmd_func == FUNC_W'(3))
      |=> (rsp_result == $past(cmd_op_a & ~cmd_op_b)) && rsp_ok);

   assert_bad_code_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !rsp_ok) |-> (rsp_result == '0));

   assert_drain_empties_R10: assert property (@(posedge clk) disable iff (rst)
      (rsp_xfer && !cmd_xfer) |=> !rsp_valid);

endmodule

bind cfu_unit cfu_unit_chk #(
   .DATA_W      (DATA_W),
   .FUNC_W      (FUNC_W),
   .ENABLE_ANDN (ENABLE_ANDN)
) u_chk (.*);

// File: tb/cfu_unit_bench.sv
module cfu_unit_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [9:0]  cmd_func = '0;
   logic [31:0] cmd_op_a = '0;
   logic [31:0] cmd_op_b = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [31:0] rsp_result;
   logic        rsp_ok;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cfu_unit u_cfu_unit (
      .clk        (clk),
      .rst        (rst),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_func   (cmd_func),
      .cmd_op_a   (cmd_op_a),
      .cmd_op_b   (cmd_op_b),
      .rsp_valid  (rsp_valid),
      .rsp_ready  (rsp_ready),
      .rsp_result (rsp_result),
      .rsp_ok     (rsp_ok)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_result(input int f, input logic [31:0] a, input logic [31:0] b);
      logic [31:0] r = '0;
      case (f)
         0: for (int k = 0; k < 4; k++) r = r | (((a >> (8*k)) & 32'hFF) << (8*(3-k)));
         1: for (int k = 0; k < 32; k++) if (a[k]) r = r + (32'd1 << (31-k));
         2: r = a + b;
         3: r = a ^ (a & b);
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string req_of(input int f);
      case (f)
         0: return "R5";
         1: return "R6";
         2: return "R7";
         3: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic run_cmd(input int f, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      rsp_ready = 1'b1;
      cmd_valid = 1'b1;
      cmd_func  = 10'(f);
      cmd_op_a  = a;
      cmd_op_b  = b;
      #1 chk("R2 ready when empty", 32'(cmd_ready), 32'd1);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R3 valid after accept", 32'(rsp_valid), 32'd1);
      chk(req_of(f), rsp_result, ref_result(f, a, b));
      chk(req_of(f), 32'(rsp_ok), (f < 4) ? 32'd1 : 32'd0);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [31:0] pa [3];
      logic [31:0] pb [3];
      pa[0] = 32'h1234_5678; pb[0] = 32'h0F0F_00FF;
      pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0001;
      pa[2] = 32'h8000_0001; pb[2] = 32'hA5A5_5A5A;

      // Reset state (R1)
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 valid after reset", 32'(rsp_valid), 32'd0);
      chk("R1 result after reset", rsp_result, 32'd0);
      chk("R1 ok after reset", 32'(rsp_ok), 32'd0);
      chk("R2 ready after reset", 32'(cmd_ready), 32'd1);

      // Sweep every function code (R5..R9)
      for (int f = 0; f < 1024; f++) begin
         for (int p = 0; p < 3; p++) begin
            if (f < 8 || p == (f % 3)) run_cmd(f, pa[p], pb[p]);
         end
      end
      // Extra pseudo-random operands on the supported codes
      begin
         logic [31:0] s = 32'hC0FF_EE01;
         for (int n = 0; n < 64; n++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            run_cmd(n % 4, s, {s[15:0], s[31:16]} ^ 32'h5555_AAAA);
         end
      end
      @(negedge clk);
      chk("R10 empty after drain", 32'(rsp_valid), 32'd0);

      // Stall, then replace in the same edge (R2, R4, R10)
      rsp_ready = 1'b0;
      cmd_valid = 1'b1;
      cmd_func  = 10'd0;
      cmd_op_a  = 32'hDEAD_BEEF;
      cmd_op_b  = 32'h0;
      #1 chk("R2 ready when empty", 32'(cmd_ready), 32'd1);
      @(negedge clk);
      chk("R3 valid after accept", 32'(rsp_valid), 32'd1);
      cmd_func = 10'd2;
      cmd_op_a = 32'h7000_0000;
      cmd_op_b = 32'h9000_0005;
      #1 chk("R2 blocked when full", 32'(cmd_ready), 32'd0);
      for (int w = 0; w < 3; w++) begin
         @(negedge clk);
         chk("R4 valid held", 32'(rsp_valid), 32'd1);
         chk("R4 result held", rsp_result, 32'hEFBE_ADDE);
         chk("R4 ok held", 32'(rsp_ok), 32'd1);
      end
      rsp_ready = 1'b1;
      #1 chk("R2 ready on drain", 32'(cmd_ready), 32'd1);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R10 replaced valid", 32'(rsp_valid), 32'd1);
      chk("R10 replaced result", rsp_result, 32'h0000_0005);
      @(negedge clk);
      chk("R10 empty after drain", 32'(rsp_valid), 32'd0);

      // Streaming one command per cycle (R10)
      for (int n = 0; n < 6; n++) begin
         cmd_valid = 1'b1;
         cmd_func  = 10'(n % 4);
         cmd_op_a  = 32'h0102_0304 * 32'(n + 1);
         cmd_op_b  = 32'h0011_2233 + 32'(n);
         #1 chk("R10 ready while streaming", 32'(cmd_ready), 32'd1);
         @(negedge clk);
         chk("R10 stream valid", 32'(rsp_valid), 32'd1);
         chk("R10 stream result", rsp_result,
             ref_result(n % 4, 32'h0102_0304 * 32'(n + 1), 32'h0011_2233 + 32'(n)));
      end
      cmd_valid = 1'b0;
      @(negedge clk);
      chk("R10 empty after stream", 32'(rsp_valid), 32'd0);

      // Reset while a response is stalled (R1)
      rsp_ready = 1'b0;
      cmd_valid = 1'b1;
      cmd_func  = 10'd1;
      cmd_op_a  = 32'h0000_0001;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R6 stalled result", rsp_result, 32'h8000_0000);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 valid cleared", 32'(rsp_valid), 32'd0);
      chk("R1 result cleared", rsp_result, 32'd0);
      chk("R2 ready after reset", 32'(cmd_ready), 32'd1);
      rsp_ready = 1'b1;

      repeat (2) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule